// File: doc/BRIEF.md
# Dual Lamp Channel Sequencer

This block runs the control sequence for two independent lamp channels. Each channel starts in a supply check and moves to a strike attempt once the supplies are acceptable. When lamp current is seen it enters a run phase. On trouble it goes through fault handling, which can retry a bounded number of times before it latches a fault. The block does not generate gate waveforms. It tells a separate duty controller, per channel, whether the gates may be driven. It also reports whether the channel is striking, running or latched faulted.

Status flags come from analog comparators that run on no particular clock. All of them, including the power-down pin, pass through two-flop synchronizers before the state machines see them. Timeouts and retry waits are counted on a lamp-cycle tick input. Configuration bits select the strike timeout, enable auto-retry, and choose whether one channel's fault also shuts the other channel down.

Each channel has five states. CHECK waits for supply. STRIKE ramps the lamp. RUN is normal operation. HOLDOFF is the wait between retries. FAULT is latched. The transitions are:
- supply-ok (CHECK→STRIKE);
- struck (STRIKE→RUN);
- strike-timeout or overvoltage (STRIKE→HOLDOFF or FAULT);
- lamp-out (RUN→HOLDOFF or FAULT);
- overcurrent (STRIKE/RUN→FAULT);
- holdoff-done (HOLDOFF→STRIKE);
- drop (STRIKE/RUN/HOLDOFF→CHECK on supply loss, shutdown or cross-channel kill);
- release (FAULT→CHECK).

Top module: `lamp_seq_top`

## Requirements
- R1: A channel leaves CHECK only when all of these hold: `vcc_ok`=1, `mon_lo_above`=1, `mon_hi_above`=0, no power-down (pin or software) and its `ch_off` bit is 0.
- R2: In STRIKE, `striking` and `gate_en` are 1. Synchronized lamp current (`lamp_on`) moves the channel to RUN, where `running` and `gate_en` are 1.
- R3: A strike that sees no lamp current ends after 256 << `strike_sel` lamp ticks (codes 0, 1, 2, 3 select 256, 512, 1024, 2048). Cycles without a tick do not count.
- R4: Overvoltage during STRIKE drops `gate_en` in the same cycle the synchronized flag appears, and the channel enters fault handling on the next edge.
- R5: In RUN, `lamp_low` held for the selected timeout (counted in ticks) triggers fault handling. A shorter episode restarts the count and has no effect.
- R6: With `retry_en`=1, fault handling (other than overcurrent) waits 1024 ticks in HOLDOFF and then strikes again. This allows up to 14 extra strikes; after the last failure the channel latches FAULT.
- R7: With `retry_en`=0, fault handling latches FAULT directly.
- R8: Overcurrent in STRIKE or RUN latches FAULT on the next state update, with no retry.
- R9: With `fault_all`=1, a channel in FAULT holds every other channel in CHECK with its gates off. With `fault_all`=0, channels are independent.
- R10: FAULT persists until one of these occurs: supply not ok, the power-down pin, the software power-down bit, or the channel's own `ch_off`. Any of them returns the channel to CHECK.
- R11: The retry count restarts whenever a channel reaches RUN or leaves FAULT, so a later fault again gets 14 extra strikes.
- R12: A change on a status input reaches the state outputs after three clock edges: two synchronizer stages plus the state register.
- R13: Loss of supply in STRIKE, RUN or HOLDOFF returns the channel to CHECK with the gates off, without latching a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Lamp-cycle tick, one cycle wide, synchronous |
| vcc_ok | input | 1 | Main supply above undervoltage level (asynchronous) |
| mon_lo_above | input | 1 | Low supply monitor above its threshold (asynchronous) |
| mon_hi_above | input | 1 | High supply monitor above its threshold (asynchronous) |
| pwr_down_pin | input | 1 | Power-down pin (asynchronous) |
| pwr_down_sw | input | 1 | Software power-down bit |
| lamp_on | input | NCH | Lamp current present, per channel (asynchronous) |
| lamp_low | input | NCH | Lamp current below lamp-out reference, per channel (asynchronous) |
| over_v | input | NCH | Overvoltage, per channel (asynchronous) |
| over_i | input | NCH | Overcurrent, per channel (asynchronous) |
| ch_off | input | NCH | Per-channel disable bit |
| retry_en | input | 1 | Enable automatic retry |
| fault_all | input | 1 | A fault in one channel shuts down all channels |
| strike_sel | input | 2 | Timeout select |
| gate_en | output | NCH | Gate drive allowed |
| striking | output | NCH | Channel in STRIKE |
| running | output | NCH | Channel in RUN |
| faulted | output | NCH | Channel latched in FAULT |

## Verification
The assertions assume that the configuration bits and the `ch_off` bits change only while a channel is not mid-decision. They also assume that the tick is a single-cycle synchronous pulse. Their antecedents are built from synchronized flags, so they hold however the raw comparator inputs move. The stimulus holds each status input steady for several cycles after every change. Configuration is changed only while the affected channel is parked in CHECK or FAULT. The tick is either held high or held low for long stretches.

// File: rtl/lamp_seq_pkg.sv
package lamp_seq_pkg;

    typedef enum logic [2:0] {
        CH_CHECK,
        CH_STRIKE,
        CH_RUN,
        CH_HOLDOFF,
        CH_FAULT
    } ch_state_e;

    typedef struct packed {
        logic lamp_on;
        logic lamp_low;
        logic over_v;
        logic over_i;
    } ch_flags_t;

endpackage

// File: rtl/lamp_sync2.sv
module lamp_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/lamp_tick_timer.sv
module lamp_tick_timer #(
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          expire
);
    logic [CW-1:0] cnt;

    assign expire = en && tick && (cnt == limit - CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en && tick) begin
            cnt <= expire ? '0 : cnt + CW'(1);
        end
    end
endmodule

// File: rtl/lamp_chan_fsm.sv
module lamp_chan_fsm
    import lamp_seq_pkg::*;
#(
    parameter int BASE_TICKS = 256,
    parameter int WAIT_TICKS = 1024,
    parameter int MAX_RETRY  = 14,
    parameter int CW         = 13,
    parameter int RW         = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      sup_ok,
    input  logic      stop,
    input  logic      kill,
    input  ch_flags_t flg,
    input  logic      retry_en,
    input  logic [1:0] tsel,
    output logic      gate_en,
    output logic      striking,
    output logic      running,
    output logic      faulted
);
    ch_state_e     st, nxt, handle_st;
    logic [RW-1:0] retry_cnt;
    logic [CW-1:0] limit;
    logic          tmr_en, tmr_clr, expire;
    logic          drop;

    assign drop      = !sup_ok || stop || kill;
    assign handle_st = (retry_en && retry_cnt != RW'(MAX_RETRY)) ? CH_HOLDOFF : CH_FAULT;
    assign limit     = (st == CH_HOLDOFF) ? CW'(WAIT_TICKS) : (CW'(BASE_TICKS) << tsel);

    always_comb begin
        nxt = st;
        unique case (st)
            CH_CHECK: begin
                if (!drop) nxt = CH_STRIKE;
            end
            CH_STRIKE: begin
                if (drop)             nxt = CH_CHECK;
                else if (flg.over_i)  nxt = CH_FAULT;
                else if (flg.over_v)  nxt = handle_st;
                else if (flg.lamp_on) nxt = CH_RUN;
                else if (expire)      nxt = handle_st;
            end
            CH_RUN: begin
                if (drop)            nxt = CH_CHECK;
                else if (flg.over_i) nxt = CH_FAULT;
                else if (expire)     nxt = handle_st;
            end
            CH_HOLDOFF: begin
                if (drop)        nxt = CH_CHECK;
                else if (expire) nxt = CH_STRIKE;
            end
            CH_FAULT: begin
                if (!sup_ok || stop) nxt = CH_CHECK;
            end
            default: nxt = CH_CHECK;
        endcase
    end

    assign tmr_en  = (st == CH_STRIKE) || (st == CH_HOLDOFF) ||
                     ((st == CH_RUN) && flg.lamp_low);
    assign tmr_clr = (nxt != st) || ((st == CH_RUN) && !flg.lamp_low);

    lamp_tick_timer #(.CW(CW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .en     (tmr_en),
        .tick   (tick),
        .limit  (limit),
        .expire (expire)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= CH_CHECK;
            retry_cnt <= '0;
        end else begin
            st <= nxt;
            if (nxt == CH_RUN || nxt == CH_CHECK)
                retry_cnt <= '0;
            else if (nxt == CH_HOLDOFF && st != CH_HOLDOFF)
                retry_cnt <= retry_cnt + RW'(1);
        end
    end

    always_comb begin
        gate_en  = 1'b0;
        striking = 1'b0;
        running  = 1'b0;
        faulted  = 1'b0;
        unique case (st)
            CH_STRIKE: begin
                striking = 1'b1;
                gate_en  = !flg.over_v;
            end
            CH_RUN: begin
                running = 1'b1;
                gate_en = 1'b1;
            end
            CH_FAULT: faulted = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/lamp_seq_top.sv
module lamp_seq_top
    import lamp_seq_pkg::*;
#(
    parameter int NCH        = 2,
    parameter int BASE_TICKS = 256,
    parameter int WAIT_TICKS = 1024,
    parameter int MAX_RETRY  = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           vcc_ok,
    input  logic           mon_lo_above,
    input  logic           mon_hi_above,
    input  logic           pwr_down_pin,
    input  logic           pwr_down_sw,
    input  logic [NCH-1:0] lamp_on,
    input  logic [NCH-1:0] lamp_low,
    input  logic [NCH-1:0] over_v,
    input  logic [NCH-1:0] over_i,
    input  logic [NCH-1:0] ch_off,
    input  logic           retry_en,
    input  logic           fault_all,
    input  logic [1:0]     strike_sel,
    output logic [NCH-1:0] gate_en,
    output logic [NCH-1:0] striking,
    output logic [NCH-1:0] running,
    output logic [NCH-1:0] faulted
);
    localparam int MAXCNT = (BASE_TICKS * 8 > WAIT_TICKS) ? BASE_TICKS * 8 : WAIT_TICKS;
    localparam int CW     = $clog2(MAXCNT) + 1;
    localparam int RW     = $clog2(MAX_RETRY + 1);
    localparam int SW     = 4 + 4 * NCH;

    logic [SW-1:0]  raw_v, syn_v;
    logic           vcc_s, lo_s, hi_s, pdn_s, sup_ok_s;
    logic [NCH-1:0] lon_s, llow_s, ovp_s, ocp_s;

    assign raw_v = {vcc_ok, mon_lo_above, mon_hi_above, pwr_down_pin,
                    lamp_on, lamp_low, over_v, over_i};

    lamp_sync2 #(.W(SW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_v),
        .q     (syn_v)
    );

    assign {vcc_s, lo_s, hi_s, pdn_s, lon_s, llow_s, ovp_s, ocp_s} = syn_v;
    assign sup_ok_s = vcc_s && lo_s && !hi_s;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        ch_flags_t flg;
        logic      kill, stop;

        assign flg.lamp_on  = lon_s[c];
        assign flg.lamp_low = llow_s[c];
        assign flg.over_v   = ovp_s[c];
        assign flg.over_i   = ocp_s[c];
        assign stop = pdn_s || pwr_down_sw || ch_off[c];
        assign kill = fault_all && ((faulted & ~(NCH'(1) << c)) != '0);

        lamp_chan_fsm #(
            .BASE_TICKS (BASE_TICKS),
            .WAIT_TICKS (WAIT_TICKS),
            .MAX_RETRY  (MAX_RETRY),
            .CW         (CW),
            .RW         (RW)
        ) u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .sup_ok   (sup_ok_s),
            .stop     (stop),
            .kill     (kill),
            .flg      (flg),
            .retry_en (retry_en),
            .tsel     (strike_sel),
            .gate_en  (gate_en[c]),
            .striking (striking[c]),
            .running  (running[c]),
            .faulted  (faulted[c])
        );
    end
endmodule

// File: rtl/lamp_seq_chk.sv
module lamp_seq_chk #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           sup_ok_s,
    input logic           pdn_s,
    input logic           pwr_down_sw,
    input logic [NCH-1:0] ch_off,
    input logic [NCH-1:0] ovp_s,
    input logic [NCH-1:0] ocp_s,
    input logic           fault_all,
    input logic [NCH-1:0] gate_en,
    input logic [NCH-1:0] striking,
    input logic [NCH-1:0] running,
    input logic [NCH-1:0] faulted
);
    for (genvar c = 0; c < NCH; c++) begin : g_c
        localparam int O = (c + 1) % NCH;
        logic release_c, kill_c;
        assign release_c = !sup_ok_s || pdn_s || pwr_down_sw || ch_off[c];
        assign kill_c    = fault_all && ((faulted & ~(NCH'(1) << c)) != '0);

        // R2
        state_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({striking[c], running[c], faulted[c]}) &&
            (!gate_en[c] || striking[c] || running[c]));

        // R1
        strike_needs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(striking[c]) |-> $past(sup_ok_s));

        // R4
        ovp_leaves_strike_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (striking[c] && ovp_s[c] && !release_c && !kill_c) |=> (!striking[c] && !running[c]));

        // R8
        ocp_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((striking[c] || running[c]) && ocp_s[c] && !release_c && !kill_c) |=> faulted[c]);

        // R10
        fault_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (faulted[c] && !release_c) |=> faulted[c]);

        // R9
        fault_all_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(faulted[c]) && fault_all && O != c) |=> !gate_en[O]);
    end
endmodule

bind lamp_seq_top lamp_seq_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sup_ok_s    (sup_ok_s),
    .pdn_s       (pdn_s),
    .pwr_down_sw (pwr_down_sw),
    .ch_off      (ch_off),
    .ovp_s       (ovp_s),
    .ocp_s       (ocp_s),
    .fault_all   (fault_all),
    .gate_en     (gate_en),
    .striking    (striking),
    .running     (running),
    .faulted     (faulted)
);

// File: tb/tb_lamp_seq_top.sv
module tb_lamp_seq_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       vcc_ok = 1'b0, mon_lo_above = 1'b0, mon_hi_above = 1'b0;
    logic       pwr_down_pin = 1'b0, pwr_down_sw = 1'b0;
    logic [1:0] lamp_on = '0, lamp_low = '0, over_v = '0, over_i = '0, ch_off = '0;
    logic       retry_en = 1'b0, fault_all = 1'b0;
    logic [1:0] strike_sel = 2'd0;
    logic [1:0] gate_en, striking, running, faulted;

    always #10 clk = ~clk;

    lamp_seq_top dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .vcc_ok(vcc_ok),
        .mon_lo_above(mon_lo_above), .mon_hi_above(mon_hi_above),
        .pwr_down_pin(pwr_down_pin), .pwr_down_sw(pwr_down_sw),
        .lamp_on(lamp_on), .lamp_low(lamp_low), .over_v(over_v), .over_i(over_i),
        .ch_off(ch_off), .retry_en(retry_en), .fault_all(fault_all),
        .strike_sel(strike_sel), .gate_en(gate_en), .striking(striking),
        .running(running), .faulted(faulted)
    );

    typedef struct {
        string      req;
        int         ch;
        logic [3:0] exp;
    } item_t;

    item_t q[$];
    int    compared = 0;
    int    mismatched = 0;
    bit    done = 1'b0;

    // expected code per channel: {gate_en, striking, running, faulted}
    localparam logic [3:0] IDLE = 4'b0000, STRK = 4'b1100, RUNS = 4'b1010,
                           FLT = 4'b0001, STRK_NOGATE = 4'b0100;

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_ch(input string r, input int ch, input logic [3:0] e);
        item_t it;
        it.req = r; it.ch = ch; it.exp = e;
        q.push_back(it);
        #2;
    endtask

    task automatic chk_int(input string r, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", r, act, exp);
        end
    endtask

    initial begin : monitor
        forever begin
            wait (q.size() != 0);
            #1;
            while (q.size() != 0) begin
                item_t it;
                logic [3:0] act;
                it = q.pop_front();
                act = {gate_en[it.ch], striking[it.ch], running[it.ch], faulted[it.ch]};
                compared++;
                if (act !== it.exp) begin
                    mismatched++;
                    $display("FAIL %s ch%0d: actual %b expected %b", it.req, it.ch, act, it.exp);
                end
            end
        end
    end

    task automatic pulse_off0();
        ch_off[0] = 1'b1;
        cyc(4);
        ch_off[0] = 1'b0;
    endtask

    // counts strike entries of ch0 until it latches FAULT; returns count
    task automatic count_strikes(output int n, output int r1, output int f1, output int r2,
                                 input int stop_after);
        logic prev;
        prev = striking[0];
        n = 0; r1 = -1; f1 = -1; r2 = -1;
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (striking[0] && !prev) begin
                n++;
                if (n == 1) r1 = i;
                if (n == 2) r2 = i;
            end
            if (!striking[0] && prev && f1 < 0) f1 = i;
            prev = striking[0];
            if (faulted[0]) break;
            if (stop_after > 0 && n == stop_after) break;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin : driver
        int n, r1, f1, r2;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        expect_ch("R1 reset", 0, IDLE);
        expect_ch("R1 reset", 1, IDLE);

        // R1: high monitor above threshold blocks strike
        vcc_ok = 1; mon_lo_above = 1; mon_hi_above = 1; lamp_on = 2'b11;
        cyc(8);
        expect_ch("R1 hi monitor", 0, IDLE);
        expect_ch("R1 hi monitor", 1, IDLE);

        // R12 latency, R2 strike then run
        mon_hi_above = 0;
        cyc(2);
        expect_ch("R12 two edges", 0, IDLE);
        cyc(1);
        expect_ch("R12 third edge", 0, STRK);
        cyc(1);
        expect_ch("R2 struck", 0, RUNS);
        expect_ch("R2 struck", 1, RUNS);

        // R5 short lamp-out ignored, long lamp-out -> fault (R7 no retry)
        lamp_low[0] = 1; cyc(100); lamp_low[0] = 0; cyc(5);
        expect_ch("R5 short dip", 0, RUNS);
        lamp_low[0] = 1; cyc(200);
        expect_ch("R5 before timeout", 0, RUNS);
        cyc(70);
        expect_ch("R7 lamp-out latched", 0, FLT);
        expect_ch("R9 independent", 1, RUNS);
        lamp_low[0] = 0;

        // R10 fault persists, channel disable releases it
        cyc(10);
        expect_ch("R10 persists", 0, FLT);
        ch_off[0] = 1; cyc(5);
        expect_ch("R10 released", 0, IDLE);
        expect_ch("R10 other ch", 1, RUNS);
        ch_off[0] = 0; cyc(6);
        expect_ch("R10 restart", 0, RUNS);

        // R8 overcurrent latches without retry
        retry_en = 1;
        over_i[0] = 1; cyc(4);
        expect_ch("R8 ocp", 0, FLT);
        over_i[0] = 0; cyc(1100);
        expect_ch("R8 no retry", 0, FLT);
        pwr_down_sw = 1; cyc(2);
        expect_ch("R10 sw pdn", 0, IDLE);
        expect_ch("R10 sw pdn", 1, IDLE);
        pwr_down_sw = 0; cyc(4);
        expect_ch("R10 after pdn", 0, RUNS);
        expect_ch("R10 after pdn", 1, RUNS);

        // R9 fault_all
        fault_all = 1; retry_en = 0;
        over_i[1] = 1; cyc(5);
        expect_ch("R9 faulted", 1, FLT);
        expect_ch("R9 killed", 0, IDLE);
        over_i[1] = 0; cyc(20);
        expect_ch("R9 held", 0, IDLE);
        pwr_down_pin = 1; cyc(4);
        expect_ch("R10 pin", 1, IDLE);
        pwr_down_pin = 0; fault_all = 0; cyc(6);
        expect_ch("R9 recovered", 0, RUNS);
        expect_ch("R9 recovered", 1, RUNS);

        // R4 overvoltage in strike
        lamp_on[0] = 0; ch_off[0] = 1; cyc(4);
        ch_off[0] = 0; cyc(2);
        expect_ch("R4 striking", 0, STRK);
        over_v[0] = 1; cyc(2);
        expect_ch("R4 gate off", 0, STRK_NOGATE);
        cyc(1);
        expect_ch("R4 fault", 0, FLT);
        over_v[0] = 0;

        // R3 tick gating
        pulse_off0(); cyc(100); tick = 0; cyc(400);
        expect_ch("R3 no tick", 0, STRK);
        tick = 1; cyc(140);
        expect_ch("R3 partial", 0, STRK);
        cyc(30);
        expect_ch("R3 sel0 timeout", 0, FLT);

        // R3 select 1 and 3
        strike_sel = 2'd1; pulse_off0(); cyc(500);
        expect_ch("R3 sel1 before", 0, STRK);
        cyc(20);
        expect_ch("R3 sel1 after", 0, FLT);
        strike_sel = 2'd3; pulse_off0(); cyc(2040);
        expect_ch("R3 sel3 before", 0, STRK);
        cyc(20);
        expect_ch("R3 sel3 after", 0, FLT);
        strike_sel = 2'd0;

        // R6 retry sequence
        ch_off[0] = 1; retry_en = 1; cyc(4); ch_off[0] = 0;
        count_strikes(n, r1, f1, r2, 0);
        chk_int("R6 strike count", n, 15);
        chk_int("R6 strike length", f1 - r1, 256);
        chk_int("R6 holdoff length", r2 - f1, 1024);
        expect_ch("R6 latched", 0, FLT);

        // R11 retry count cleared by run
        ch_off[0] = 1; cyc(4); ch_off[0] = 0;
        count_strikes(n, r1, f1, r2, 3);
        lamp_on[0] = 1; cyc(5);
        expect_ch("R11 run", 0, RUNS);
        lamp_on[0] = 0; lamp_low[0] = 1;
        count_strikes(n, r1, f1, r2, 0);
        chk_int("R11 fresh retries", n, 14);
        lamp_low[0] = 0;

        // R13 supply loss, R1 low monitor
        lamp_on[0] = 1; pulse_off0(); cyc(6);
        expect_ch("R13 run", 0, RUNS);
        vcc_ok = 0; cyc(4);
        expect_ch("R13 drop", 0, IDLE);
        expect_ch("R13 drop", 1, IDLE);
        mon_lo_above = 0; vcc_ok = 1; cyc(6);
        expect_ch("R1 lo monitor", 0, IDLE);
        mon_lo_above = 1; cyc(5);
        expect_ch("R13 restart", 0, RUNS);
        expect_ch("R13 restart", 1, RUNS);

        cyc(2);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule